// File: doc/BRIEF.md
# Double-Edge Four-Lane Serializer

This block merges four parallel one-bit lanes into a single serial stream. It runs from a half-rate clock: one serial bit leaves on the rising edge and another on the falling edge, so the stream carries four times the lane rate. The block also divides the half-rate clock by four and drives the result out as a word clock.

Upstream logic launches each new four-bit word on an edge of the word clock. The serializer samples the lanes on the next edge of that clock. Both edges of the word clock are used, so a fresh word enters every two half-rate periods and follows the previous one with no gap.

Only the half-rate clock is used inside. Rising-edge logic prepares a pair of bits. A falling-edge register holds the second bit of the pair. The clock level selects which of the two drives the output. No part of the timing assumes that the high and low halves of the input clock are equal.

Top module: `ddr_serializer`

## Requirements
- R1: The serial output carries a new bit after every rising and every falling edge of `hclk`, so four lane bits leave in two `hclk` periods.
- R2: Within each captured word the transmit order is lane 0, lane 1, lane 2, lane 3, where lane i is bit i of `lanes`.
- R3: `divClk` is `hclk` divided by four, with a 50 percent duty cycle: it changes only on rising edges of `hclk`, and it changes on every second rising edge.
- R4: The lanes are sampled on every rising edge of `hclk` at which `divClk` changes, so one new word is taken on each edge of `divClk`.
- R5: The latency is fixed. For a word sampled at rising edge k, lane 0 drives the output in the high phase after edge k+1 and lane 1 in the low phase after it. Lane 2 follows in the high phase after edge k+2 and lane 3 in the low phase after it. The last bit of one word is followed directly by the first bit of the next.
- R6: While `rstN` is low, `serOut` and `divClk` are 0. After release, `divClk` first rises on the second rising edge of `hclk`. `serOut` stays 0 until the first captured word appears.
- R7: The output order and latency stay correct for `hclk` duty cycles of 40 and 60 percent.
- R8: Changes on `lanes` between two `divClk` edges have no effect on the serial output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Half-rate clock; both edges shift out a bit |
| rstN | input | 1 | Asynchronous active-low reset |
| lanes | input | LANES (4) | Parallel lane bits, aligned to `divClk` |
| serOut | output | 1 | Serial stream at twice the `hclk` frequency |
| divClk | output | 1 | Word clock, `hclk` divided by four |

## Verification
On every cycle, the bound checker checks three things. It checks the cadence of `divClk`. It checks that both outputs stay quiet in reset. It checks that lane 0 and lane 1 of each word sampled on a `divClk` edge appear in the expected high and low phases one `hclk` period later.

Only the bench's scenarios can show the rest. These are the placement of lanes 2 and 3 and the seamless join between words. They also include the exact start-up sequence after reset and the behaviour under skewed `hclk` duty cycles. Finally, the bench shows that lane values toggled between word-clock edges never leak into the stream.

// File: rtl/ddr_ser_pkg.sv
package ddr_ser_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // strobes from the pacing control to the shift datapath
  typedef struct packed {
    logic loadWord;   // sample the lanes on this rising edge
    logic shiftPair;  // advance the shift register by one bit pair
  } strobe_t;
endpackage

// File: rtl/ddr_ser_ctrl.sv
module ddr_ser_ctrl #(
  parameter int LANES = 4
) (
  input  logic                 hclk,
  input  logic                 rstN,
  output ddr_ser_pkg::strobe_t strobe,
  output logic                 divClk
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int PAIRS = LANES / 2;
  localparam int CW    = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  logic [CW-1:0] pairCnt;
  logic          lastPair;

  assign lastPair = (pairCnt == CW'(PAIRS - 1));

  always_ff @(posedge hclk or negedge rstN) begin
    if (!rstN) begin
      pairCnt <= '0;
      divClk  <= 1'b0;
    end else if (lastPair) begin
      pairCnt <= '0;
      divClk  <= ~divClk;
    end else begin
      pairCnt <= pairCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.loadWord  = lastPair;
    strobe.shiftPair = ~lastPair;
  end
endmodule

// File: rtl/ddr_ser_dpath.sv
module ddr_ser_dpath #(
  parameter int LANES = 4
) (
  input  logic                 hclk,
  input  logic                 rstN,
  input  ddr_ser_pkg::strobe_t strobe,
  input  logic [LANES-1:0]     lanes,
  output logic                 serOut
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [LANES-1:0] shReg;
  logic [LANES-1:0] shNext;
  logic             riseBit;
  logic             nextFall;
  logic             fallBit;

  // shift by one bit pair, zero fill from the top
  for (genvar i = 0; i < LANES; i++) begin : g_shift
    if (i + 2 < LANES) begin : g_move
      assign shNext[i] = shReg[i+2];
    end else begin : g_fill
      assign shNext[i] = 1'b0;
    end
  end

  always_ff @(posedge hclk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      riseBit  <= 1'b0;
      nextFall <= 1'b0;
    end else begin
      riseBit  <= shReg[0];
      nextFall <= shReg[1];
      if (strobe.loadWord) begin
        shReg <= lanes;
      end else if (strobe.shiftPair) begin
        shReg <= shNext;
      end
    end
  end

  always_ff @(negedge hclk or negedge rstN) begin
    if (!rstN) begin
      fallBit <= 1'b0;
    end else begin
      fallBit <= nextFall;
    end
  end

  // clock level picks the half: high phase shows the rise bit
  assign serOut = hclk ? riseBit : fallBit;
endmodule

// File: rtl/ddr_serializer.sv
module ddr_serializer #(
  parameter int LANES = 4
) (
  input  logic             hclk,
  input  logic             rstN,
  input  logic [LANES-1:0] lanes,
  output logic             serOut,
  output logic             divClk
);
  timeunit 1ns;
  timeprecision 1ps;

  ddr_ser_pkg::strobe_t strobe;

  ddr_ser_ctrl #(.LANES(LANES)) u_ctrl (
    .hclk   (hclk),
    .rstN   (rstN),
    .strobe (strobe),
    .divClk (divClk)
  );

  ddr_ser_dpath #(.LANES(LANES)) u_dpath (
    .hclk   (hclk),
    .rstN   (rstN),
    .strobe (strobe),
    .lanes  (lanes),
    .serOut (serOut)
  );
endmodule

// File: rtl/ddr_serializer_chk.sv
module ddr_serializer_chk #(
  parameter int LANES = 4
) (
  input logic             hclk,
  input logic             rstN,
  input logic [LANES-1:0] lanes,
  input logic             serOut,
  input logic             divClk
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int PAIRS = LANES / 2;
  localparam int EW    = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  logic [EW-1:0]    edgeCnt;
  logic [LANES-1:0] capWord;
  logic             loadSeen;
  logic             firstPairDue;

  always_ff @(posedge hclk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt      <= '0;
      capWord      <= '0;
      loadSeen     <= 1'b0;
      firstPairDue <= 1'b0;
    end else begin
      edgeCnt      <= (edgeCnt == EW'(PAIRS - 1)) ? '0 : edgeCnt + 1'b1;
      loadSeen     <= (edgeCnt == EW'(PAIRS - 1));
      firstPairDue <= loadSeen;
      if (edgeCnt == EW'(PAIRS - 1)) capWord <= lanes;
    end
  end

  always @(posedge hclk) begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (serOut == 1'b0 && divClk == 1'b0); // R6
    end
  end

  AST_DIV_TOGGLE: assert property (@(posedge hclk) disable iff (!rstN)
    (edgeCnt == EW'(PAIRS - 1)) |=> (divClk != $past(divClk))); // R3
  AST_DIV_HOLD: assert property (@(posedge hclk) disable iff (!rstN)
    (edgeCnt != EW'(PAIRS - 1)) |=> $stable(divClk)); // R3
  AST_LANE0_HIGH: assert property (@(negedge hclk) disable iff (!rstN)
    firstPairDue |-> (serOut == capWord[0])); // R5
  AST_LANE1_LOW: assert property (@(posedge hclk) disable iff (!rstN)
    firstPairDue |-> (serOut == capWord[1])); // R2
endmodule

bind ddr_serializer ddr_serializer_chk #(.LANES(LANES)) u_chk (
  .hclk   (hclk),
  .rstN   (rstN),
  .lanes  (lanes),
  .serOut (serOut),
  .divClk (divClk)
);

// File: tb/ddr_serializer_bench.sv
module ddr_serializer_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LANES = 4;
  localparam int RUN   = 120;

  logic             hclk = 1'b0;
  logic             rstN = 1'b1;
  logic [LANES-1:0] lanes = '0;
  logic             serOut;
  logic             divClk;

  realtime hiT = 4.0;
  realtime loT = 4.0;
  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  ddr_serializer #(.LANES(LANES)) u_ddr_serializer (
    .hclk   (hclk),
    .rstN   (rstN),
    .lanes  (lanes),
    .serOut (serOut),
    .divClk (divClk)
  );

  initial forever begin
    #(loT) hclk = 1'b1;
    #(hiT) hclk = 1'b0;
  end

  // word number m (m >= 1): first sixteen sweep every value, then a mix
  function automatic logic [3:0] wordAt(input int m);
    if (m <= 16) return 4'(m - 1);
    return 4'((m * 7) ^ (m >> 2) ^ 5);
  endfunction

  // bit expected after rising edge n (counted from reset release)
  function automatic logic expBit(input int n, input bit lowHalf);
    int m;
    logic [3:0] w;
    if (n % 2 == 1) begin
      m = (n - 1) / 2;
      if (m < 1) return 1'b0;
      w = wordAt(m);
      return lowHalf ? w[1] : w[0];
    end
    m = (n - 2) / 2;
    if (m < 1) return 1'b0;
    w = wordAt(m);
    return lowHalf ? w[3] : w[2];
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    string tag;
    #1 rstN = 1'b0;
    lanes = 4'hF;
    repeat (3) begin
      @(posedge hclk);
      #1;
      check("R6 serOut in reset", serOut, 1'b0);
      check("R6 divClk in reset", divClk, 1'b0);
    end
    @(negedge hclk);
    lanes = wordAt(1);
    #2 rstN = 1'b1;

    for (int n = 1; n <= RUN; n++) begin
      @(posedge hclk);
      #1;
      // drive lanes aligned to divClk; phase three inserts junk mid-word
      if (n % 2 == 0) begin
        lanes = (n > 80) ? ~wordAt(n / 2 + 1) : wordAt(n / 2 + 1);
      end else if (n > 80) begin
        lanes = wordAt((n + 1) / 2);
      end
      #(hiT / 2 - 1);
      if (n <= 2)       tag = "R6 start";
      else if (n <= 40) tag = "R1 R2 R5";
      else if (n <= 80) tag = "R7 duty";
      else              tag = "R8 junk";
      check((n % 2 == 0) ? "R3 R4 divClk edge" : "R3 divClk hold",
            divClk, 1'((n >> 1) & 1));
      check({tag, " high phase"}, serOut, expBit(n, 1'b0));
      @(negedge hclk);
      #(loT / 2);
      check({tag, " low phase"}, serOut, expBit(n, 1'b1));
      if (n == 40) begin hiT = 3.2; loT = 4.8; end
      if (n == 80) begin hiT = 4.8; loT = 3.2; end
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 8.0);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule